// File: doc/BRIEF.md
# Backward Censoring Scan for Ranked Reference Cells

This block takes a window of reference cells that an upstream sorter has already ranked in ascending order. It strips interfering returns off the top of that ranking before a noise estimate is formed. The scan starts at the largest cell and moves down. At each step the current candidate is compared against a censoring threshold. That threshold is a weighted geometric blend of the smallest cell and the cell of rank p. Each step uses its own weight. The number of interfering returns does not need to be known in advance: the scan stops at the first candidate that looks like plain clutter.

All cell values arrive as unsigned fixed-point logarithms. In that domain the geometric blend becomes a weighted sum, `thr_k = floor((w_k*L + (32768-w_k)*P) / 32768)`. Here L is the smallest cell, P is the rank-p cell, and w_k is an unsigned Q1.15 weight. The block reports how many cells it censored and pulses a done flag. The final target decision and the choice of weights belong to neighbouring blocks.

Top module: `censor_scan_top`

## Requirements
- R1: After reset, `busy`, `done` and `censCount` are all 0.
- R2: A `start` pulse while idle captures `cellBus` and `weightBus`, raises `busy` one cycle later and clears `censCount` to 0.
- R3: Scan step k (k = 0, 1, ...) tests cell index NUM_CELLS-1-k of `cellBus`, taken from bits [i*16 +: 16] for cell i. The threshold is formed from the weight in `weightBus` bits [k*16 +: 16], with L = cell 0 and P = cell RANK_P-1, using the formula above. The candidate is censored when it is strictly greater than the threshold.
- R4: A candidate exactly equal to its threshold is treated as clutter and is not censored.
- R5: The scan stops at the first candidate that is not censored. `censCount` then equals the number of cells censored before it.
- R6: The scan performs at most NUM_CELLS-RANK_P steps. When every one of those steps censors, `censCount` equals NUM_CELLS-RANK_P.
- R7: One comparison happens per clock. `done` is high in the m-th cycle after the cycle in which `start` was taken. Here m is `censCount`+1 when the scan stopped on a clean cell, and NUM_CELLS-RANK_P when it ran out of steps.
- R8: `done` is a single-cycle pulse. `busy` is low while `done` is high.
- R9: A `start` that arrives while `busy` is high is ignored. The running scan finishes with the result of the window captured first.
- R10: A weight above 32768 is used as 32768, so the threshold becomes L itself.
- R11: `censCount` holds its final value after `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture a new ranked window and begin a scan |
| cellBus | input | NUM_CELLS*CELL_W | Ascending log-domain cells, cell i at bits [i*CELL_W +: CELL_W] |
| weightBus | input | (NUM_CELLS-RANK_P)*WEIGHT_W | Q1.15 weight per scan step, step k at bits [k*WEIGHT_W +: WEIGHT_W] |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse when the result is final |
| censCount | output | $clog2(NUM_CELLS-RANK_P+1) | Number of cells censored |

## Verification
The bench sweeps per-step weights across zero, intermediate values, exactly one and above one. It combines these with top-cell gaps of zero, one and large. This reaches the tie at the threshold: a design comparing with greater-or-equal would censor one cell too many. It also reaches the clamp, where an unclamped weight gives a wrapped threshold and a wrong count. Scans that censor every allowed step check the stop at NUM_CELLS-RANK_P, which an off-by-one step limit would overrun or cut short. The bench measures the exact cycle of `done` to catch an extra pipeline stage. Retriggering `start` mid-scan exposes a design that reloads its window while busy.

// File: rtl/censor_scan_pkg.sv
package censor_scan_pkg;

  // strobes issued by the sequencer to the datapath
  typedef struct packed {
    logic load;     // capture a fresh window, clear count and step
    logic advance;  // current candidate censored, move one rank down
    logic finish;   // last comparison of this scan
  } scanStrobe_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scanState_t;

endpackage

// File: rtl/censor_scan_datapath.sv
module censor_scan_datapath
  import censor_scan_pkg::*;
#(
  parameter int NUM_CELLS = 8,
  parameter int RANK_P    = 6,
  parameter int CELL_W    = 16,
  parameter int WEIGHT_W  = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  scanStrobe_t                            strobe,
  input  logic [NUM_CELLS*CELL_W-1:0]            cellBus,
  input  logic [(NUM_CELLS-RANK_P)*WEIGHT_W-1:0] weightBus,
  output logic                                   censorHit,
  output logic                                   lastStep,
  output logic [$clog2(NUM_CELLS-RANK_P+1)-1:0]  censCount
);

  localparam int STEPS  = NUM_CELLS - RANK_P;
  localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int CNT_W  = $clog2(STEPS + 1);
  localparam int FRAC   = WEIGHT_W - 1;
  localparam int WE_W   = WEIGHT_W + 1;
  localparam int PROD_W = CELL_W + WEIGHT_W + 1;
  localparam logic [WE_W-1:0] UNITY = WE_W'(1) << FRAC;

  // only the cells the scan can ever read are kept
  logic [CELL_W-1:0]   lowCell;
  logic [CELL_W-1:0]   pivotCell;
  logic [CELL_W-1:0]   topCell   [STEPS];
  logic [WEIGHT_W-1:0] stepWeight[STEPS];
  logic [STEP_W-1:0]   stepIdx;
  logic [CNT_W-1:0]    countReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lowCell   <= '0;
      pivotCell <= '0;
    end else if (strobe.load) begin
      lowCell   <= cellBus[0 +: CELL_W];
      pivotCell <= cellBus[(RANK_P-1)*CELL_W +: CELL_W];
    end
  end

  for (genvar k = 0; k < STEPS; k++) begin : g_step
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        topCell[k]    <= '0;
        stepWeight[k] <= '0;
      end else if (strobe.load) begin
        topCell[k]    <= cellBus[(NUM_CELLS-1-k)*CELL_W +: CELL_W];
        stepWeight[k] <= weightBus[k*WEIGHT_W +: WEIGHT_W];
      end
    end
  end

  // threshold in the log domain: weighted sum of low and pivot cells
  logic [CELL_W-1:0]   candidate;
  logic [WEIGHT_W-1:0] rawWeight;
  logic [WE_W-1:0]     effWeight;
  logic [PROD_W-1:0]   blend;
  logic [PROD_W-1:0]   thresh;

  always_comb begin
    candidate = topCell[stepIdx];
    rawWeight = stepWeight[stepIdx];
    effWeight = (WE_W'(rawWeight) > UNITY) ? UNITY : WE_W'(rawWeight);
    blend     = PROD_W'(effWeight) * PROD_W'(lowCell)
              + PROD_W'(UNITY - effWeight) * PROD_W'(pivotCell);
    thresh    = blend >> FRAC;
    censorHit = PROD_W'(candidate) > thresh;
    lastStep  = (stepIdx == STEP_W'(STEPS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stepIdx  <= '0;
      countReg <= '0;
    end else if (strobe.load) begin
      stepIdx  <= '0;
      countReg <= '0;
    end else if (strobe.advance) begin
      stepIdx  <= stepIdx + STEP_W'(1);
      countReg <= countReg + CNT_W'(1);
    end else if (strobe.finish) begin
      countReg <= countReg + CNT_W'(censorHit);
    end
  end

  assign censCount = countReg;

endmodule

// File: rtl/censor_scan_ctrl.sv
module censor_scan_ctrl
  import censor_scan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        censorHit,
  input  logic        lastStep,
  output scanStrobe_t strobe,
  output logic        busy,
  output logic        done
);

  scanState_t state;

  always_comb begin
    strobe         = '0;
    strobe.load    = (state == ST_IDLE) && start;
    strobe.advance = (state == ST_SCAN) && censorHit && !lastStep;
    strobe.finish  = (state == ST_SCAN) && (!censorHit || lastStep);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= strobe.finish;
      if (strobe.load)        state <= ST_SCAN;
      else if (strobe.finish) state <= ST_IDLE;
    end
  end

  assign busy = (state == ST_SCAN);

endmodule

// File: rtl/censor_scan_top.sv
module censor_scan_top
  import censor_scan_pkg::*;
#(
  parameter int NUM_CELLS = 8,
  parameter int RANK_P    = 6,
  parameter int CELL_W    = 16,
  parameter int WEIGHT_W  = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   start,
  input  logic [NUM_CELLS*CELL_W-1:0]            cellBus,
  input  logic [(NUM_CELLS-RANK_P)*WEIGHT_W-1:0] weightBus,
  output logic                                   busy,
  output logic                                   done,
  output logic [$clog2(NUM_CELLS-RANK_P+1)-1:0]  censCount
);

  scanStrobe_t strobe;
  logic        censorHit;
  logic        lastStep;

  censor_scan_ctrl uCtrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .censorHit (censorHit),
    .lastStep  (lastStep),
    .strobe    (strobe),
    .busy      (busy),
    .done      (done)
  );

  censor_scan_datapath #(
    .NUM_CELLS (NUM_CELLS),
    .RANK_P    (RANK_P),
    .CELL_W    (CELL_W),
    .WEIGHT_W  (WEIGHT_W)
  ) uPath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .cellBus   (cellBus),
    .weightBus (weightBus),
    .censorHit (censorHit),
    .lastStep  (lastStep),
    .censCount (censCount)
  );

endmodule

// File: rtl/censor_scan_checker.sv
module censor_scan_checker #(
  parameter int CNT_W = 2,
  parameter int STEPS = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] censCount
);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && censCount == '0));

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    censCount <= CNT_W'(STEPS));

  // R7
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (censCount <= $past(censCount) + CNT_W'(1)));

  // R11
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(censCount));

endmodule

bind censor_scan_top censor_scan_checker #(
  .CNT_W ($clog2(NUM_CELLS-RANK_P+1)),
  .STEPS (NUM_CELLS-RANK_P)
) uChk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .censCount (censCount)
);

// File: tb/sim_censor_scan_top.sv
module sim_censor_scan_top;

  localparam int CLK_PERIOD = 10;
  localparam int NC    = 8;
  localparam int RP    = 6;
  localparam int CW    = 16;
  localparam int WW    = 16;
  localparam int STEPS = NC - RP;
  localparam int CNT_W = $clog2(STEPS + 1);

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  start = 1'b0;
  logic [NC*CW-1:0]      cellBus = '0;
  logic [STEPS*WW-1:0]   weightBus = '0;
  logic                  busy;
  logic                  done;
  logic [CNT_W-1:0]      censCount;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  censor_scan_top #(.NUM_CELLS(NC), .RANK_P(RP), .CELL_W(CW), .WEIGHT_W(WW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cellBus(cellBus),
    .weightBus(weightBus), .busy(busy), .done(done), .censCount(censCount)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  longint cells[NC];
  longint wts[STEPS];

  function automatic longint thrOf(longint w, longint lo, longint pv);
    longint we = (w > 32768) ? 32768 : w;
    return (we * lo + (32768 - we) * pv) / 32768;
  endfunction

  function automatic int expCount();
    int c = 0;
    for (int k = 0; k < STEPS; k++) begin
      if (cells[NC-1-k] > thrOf(wts[k], cells[0], cells[RP-1])) c++;
      else break;
    end
    return c;
  endfunction

  task automatic packBus();
    for (int i = 0; i < NC; i++) cellBus[i*CW +: CW] = CW'(cells[i]);
    for (int k = 0; k < STEPS; k++) weightBus[k*WW +: WW] = WW'(wts[k]);
  endtask

  // retrig: hold start high for one extra cycle with a different window
  task automatic runScan(input string tag, input bit retrig);
    int ec = expCount();
    int em = (ec == STEPS) ? STEPS : ec + 1;
    int cyc = 0;
    bit seen = 0;
    @(negedge clk);
    packBus();
    start = 1'b1;
    @(negedge clk);
    check(busy == 1'b1 && censCount == '0, "R2 busy/clear", {busy, censCount}, 4);
    if (retrig) begin
      for (int i = 0; i < NC; i++) cellBus[i*CW +: CW] = CW'(10);
      weightBus = '0;
    end else start = 1'b0;
    while (!seen && cyc < 20) begin
      if (cyc == 1) start = 1'b0;
      @(negedge clk);
      cyc++;
      if (done) seen = 1;
    end
    start = 1'b0;
    check(seen && cyc == em, {"R7 latency ", tag}, cyc, em);
    check(censCount == CNT_W'(ec), {"R3/R5 count ", tag}, censCount, ec);
    check(!busy, "R8 busy low at done", busy, 0);
    @(negedge clk);
    check(!done, "R8 done pulse width", done, 0);
    check(censCount == CNT_W'(ec), "R11 count held", censCount, ec);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    longint wList[6]  = '{0, 8192, 16384, 24576, 32768, 50000};
    longint loList[2] = '{100, 3000};
    longint pvList[2] = '{4000, 20000};
    longint dList[3]  = '{0, 1, 900};
    string tag;
    repeat (3) @(negedge clk);
    // R1
    check(!busy && !done && censCount == '0, "R1 reset state", {busy, done, censCount}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && censCount == '0, "R1 idle after reset", {busy, done, censCount}, 0);

    // R4: top cell exactly at the threshold (weight 0 -> threshold = pivot)
    for (int i = 0; i < NC; i++) cells[i] = 500 + i * 10;
    cells[RP-1] = 700; cells[NC-2] = 700; cells[NC-1] = 700;
    wts[0] = 0; wts[1] = 0;
    runScan("R4 tie not censored", 0);
    check(censCount == '0, "R4 tie count", censCount, 0);

    // R6: every allowed step censors
    cells[NC-2] = 9000; cells[NC-1] = 9500;
    runScan("R6 exhaust", 0);
    check(censCount == CNT_W'(STEPS), "R6 limit", censCount, STEPS);

    // R9: start held during the scan with another window
    runScan("R9 retrigger ignored", 1);

    // sweep
    foreach (loList[a]) foreach (pvList[b]) foreach (dList[c]) foreach (dList[d])
    foreach (wList[e]) foreach (wList[f]) begin
      cells[0] = loList[a];
      for (int i = 1; i < RP - 1; i++)
        cells[i] = loList[a] + (pvList[b] - loList[a]) * i / (RP - 1);
      cells[RP-1] = pvList[b];
      cells[NC-2] = pvList[b] + dList[c];
      cells[NC-1] = cells[NC-2] + dList[d] * 5;
      wts[0] = wList[e];
      wts[1] = wList[f];
      tag = (wList[e] > 32768 || wList[f] > 32768) ? "R10 clamp" : "sweep";
      runScan(tag, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule